// File: doc/BRIEF.md
# Floating-Point Align, Add and Normalize Core

This block is the magnitude datapath of a single-precision adder. It takes two unpacked, finite, nonzero operands. Each operand has a sign, a two's-complement exponent of extended range and a 24-bit significand whose leading (hidden) bit is set. The block returns their sum as an unrounded sign, exponent and 27-bit significand. The three low bits of that significand are the guard, round and sticky positions. A downstream rounder and packer consume them. A separate flag marks a result that is exactly zero.

Inside, both significands are widened with three zero bits. The operand with the smaller exponent is moved right by the exponent gap, and every bit it loses is folded into its lowest bit. The magnitudes are then added or subtracted. A subtraction that cancels leading bits is renormalized over several cycles. A build parameter selects the normalizer: one position per cycle, or a leading-zero count with a barrel shift in a single step.

Both data sides use valid/ready. The input is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` stays low from that edge until the result has been handed off. The result is offered with `out_valid` and is held unchanged until `out_ready` is high at an edge. `round_down` is a plain control pin, sampled at the input handshake.

Top module: `fp_align_add_norm`

## Requirements
- R1: Each accepted input pair produces exactly one output transfer. `in_ready` is low from the accepting edge until the cycle after the output handshake, and `in_valid` has no effect during that time.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sign`, `out_exp`, `out_mant` and `out_zero` do not change.
- R3: The significand with the smaller exponent is shifted right by the exponent difference. If any bit shifted out is one, bit 0 of the shifted value is forced to one. When no carry or normalization follows, the result exponent is the larger input exponent.
- R4: An exponent difference of 27 or more reduces the smaller operand to the single value 1 at bit 0.
- R5: With equal signs the magnitudes are added. If the 28-bit sum has bit 27 set, the sum is shifted right by one, the dropped bit is ORed into bit 0, and the exponent is raised by one. The result sign is the common sign.
- R6: With different signs the smaller aligned magnitude is subtracted from the larger one. The result takes the sign of the larger one, and operand a wins a tie.
- R7: A difference of exactly zero gives `out_zero`=1, `out_mant`=0 and `out_exp`=0. `out_sign` equals `round_down`, where 1 means rounding toward minus infinity.
- R8: For every nonzero result, `out_mant[26]` is 1. The exponent is reduced by one for each position the difference was shifted left. `out_mant[26:3]` is the significand and `out_mant[2:0]` holds guard, round and sticky.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Core can accept an operand pair |
| a_sign | input | 1 | Sign of operand a |
| a_exp | input | 10 | Exponent of operand a, two's complement |
| a_mant | input | 24 | Significand of operand a, bit 23 set |
| b_sign | input | 1 | Sign of operand b |
| b_exp | input | 10 | Exponent of operand b, two's complement |
| b_mant | input | 24 | Significand of operand b, bit 23 set |
| round_down | input | 1 | 1 when rounding toward minus infinity |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | 10 | Result exponent, two's complement, unrounded |
| out_mant | output | 27 | Normalized significand with guard, round and sticky bits |
| out_zero | output | 1 | Result is exactly zero |

## Verification
The operand table is chosen so that each entry reaches a different path through the datapath:

- **Equal exponents** separate the carry case from the plain sum.
- **Gaps of 2 to 4** show whether lost bits reach the sticky position.
- **Gaps of 27 and 30** confirm that alignment collapses the smaller operand to the sticky bit alone.
- **Opposite-sign pairs** cover either operand being larger. They cover cancellation of one, one only after alignment, and 23 leading positions; these expose any error in the sign choice or in the exponent count. Exact cancellation is run under both rounding directions.
- **Handshake cases** add new operands offered while the core is busy, and a result stalled by the consumer.

// File: rtl/fpaan_pkg.sv
package fpaan_pkg;
  // Extra low positions kept below the significand: guard, round, sticky.
  localparam int GRS_BITS = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_DONE = 2'd2
  } fpaan_state_e;
endpackage

// File: rtl/fpaan_sticky_shr.sv
// Right shift in which every bit pushed out is ORed into bit 0.
module fpaan_sticky_shr #(
  parameter int W    = 27,
  parameter int SH_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,   // 0..W; W leaves only the sticky bit
  output logic [W-1:0]    dout
);
  logic [2*W-1:0] wide;

  always_comb begin
    wide = {din, {W{1'b0}}} >> amt;
    dout = {wide[2*W-1:W+1], wide[W] | (|wide[W-1:0])};
  end
endmodule

// File: rtl/fpaan_align.sv
// Widens both significands and aligns the one with the smaller exponent.
module fpaan_align #(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 10,
  localparam int W     = MANT_W + fpaan_pkg::GRS_BITS,
  localparam int SH_W  = $clog2(W + 1)
) (
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic [W-1:0]      a_al,
  output logic [W-1:0]      b_al,
  output logic [EXP_W-1:0]  big_exp
);
  logic [EXP_W:0]  gap;      // a_exp - b_exp, one bit wider
  logic [EXP_W:0]  gap_neg;
  logic            b_bigger;
  logic [SH_W-1:0] amt_a, amt_b;

  always_comb begin
    gap      = {a_exp[EXP_W-1], a_exp} - {b_exp[EXP_W-1], b_exp};
    gap_neg  = -gap;
    b_bigger = gap[EXP_W];
    big_exp  = b_bigger ? b_exp : a_exp;
    amt_a    = '0;
    amt_b    = '0;
    if (b_bigger) begin
      amt_a = (gap_neg > (EXP_W+1)'(W)) ? SH_W'(W) : SH_W'(gap_neg);
    end else begin
      amt_b = (gap > (EXP_W+1)'(W)) ? SH_W'(W) : SH_W'(gap);
    end
  end

  fpaan_sticky_shr #(.W(W)) u_shr_a (
    .din  ({a_mant, {fpaan_pkg::GRS_BITS{1'b0}}}),
    .amt  (amt_a),
    .dout (a_al)
  );

  fpaan_sticky_shr #(.W(W)) u_shr_b (
    .din  ({b_mant, {fpaan_pkg::GRS_BITS{1'b0}}}),
    .amt  (amt_b),
    .dout (b_al)
  );
endmodule

// File: rtl/fpaan_addsub.sv
// Magnitude add or subtract of aligned operands, with carry fix-up.
module fpaan_addsub #(
  parameter int W     = 27,
  parameter int EXP_W = 10
) (
  input  logic             a_sign,
  input  logic             b_sign,
  input  logic [W-1:0]     a_al,
  input  logic [W-1:0]     b_al,
  input  logic [EXP_W-1:0] exp_in,
  input  logic             round_down,
  output logic             r_sign,
  output logic [EXP_W-1:0] r_exp,
  output logic [W-1:0]     r_mant,
  output logic             r_zero
);
  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         a_ge_b;

  always_comb begin
    sum    = {1'b0, a_al} + {1'b0, b_al};
    a_ge_b = (a_al >= b_al);
    diff   = a_ge_b ? (a_al - b_al) : (b_al - a_al);
    r_zero = 1'b0;
    if (a_sign == b_sign) begin
      r_sign = a_sign;
      if (sum[W]) begin
        r_mant = {sum[W:2], sum[1] | sum[0]};
        r_exp  = exp_in + EXP_W'(1);
      end else begin
        r_mant = sum[W-1:0];
        r_exp  = exp_in;
      end
    end else if (diff == '0) begin
      r_sign = round_down;
      r_mant = '0;
      r_exp  = '0;
      r_zero = 1'b1;
    end else begin
      r_sign = a_ge_b ? a_sign : b_sign;
      r_mant = diff;
      r_exp  = exp_in;
    end
  end
endmodule

// File: rtl/fpaan_norm_step.sv
// One normalization step: a single left shift, or a full count-and-shift.
module fpaan_norm_step #(
  parameter int W         = 27,
  parameter int EXP_W     = 10,
  parameter bit FAST_NORM = 1'b0,
  localparam int SH_W     = $clog2(W + 1)
) (
  input  logic [W-1:0]     mant_in,
  input  logic [EXP_W-1:0] exp_in,
  output logic [W-1:0]     mant_out,
  output logic [EXP_W-1:0] exp_out
);
  generate
    if (FAST_NORM) begin : g_fast
      logic [SH_W-1:0] lz;
      always_comb begin
        lz = SH_W'(W);
        for (int i = 0; i < W; i++) begin
          if (mant_in[i]) lz = SH_W'(W - 1 - i);
        end
        mant_out = mant_in << lz;
        exp_out  = exp_in - EXP_W'(lz);
      end
    end else begin : g_serial
      always_comb begin
        mant_out = {mant_in[W-2:0], 1'b0};
        exp_out  = exp_in - EXP_W'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/fp_align_add_norm.sv
module fp_align_add_norm #(
  parameter int MANT_W    = 24,
  parameter int EXP_W     = 10,
  parameter bit FAST_NORM = 1'b0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  input  logic                                  a_sign,
  input  logic [EXP_W-1:0]                      a_exp,
  input  logic [MANT_W-1:0]                     a_mant,
  input  logic                                  b_sign,
  input  logic [EXP_W-1:0]                      b_exp,
  input  logic [MANT_W-1:0]                     b_mant,
  input  logic                                  round_down,
  output logic                                  out_valid,
  input  logic                                  out_ready,
  output logic                                  out_sign,
  output logic [EXP_W-1:0]                      out_exp,
  output logic [MANT_W+fpaan_pkg::GRS_BITS-1:0] out_mant,
  output logic                                  out_zero
);
  import fpaan_pkg::*;
  localparam int W = MANT_W + GRS_BITS;

  fpaan_state_e     state;
  logic             w_sign, w_zero;
  logic [EXP_W-1:0] w_exp;
  logic [W-1:0]     w_mant;

  logic [W-1:0]     a_al, b_al, r_mant, n_mant;
  logic [EXP_W-1:0] big_exp, r_exp, n_exp;
  logic             r_sign, r_zero;

  fpaan_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .a_exp   (a_exp),
    .a_mant  (a_mant),
    .b_exp   (b_exp),
    .b_mant  (b_mant),
    .a_al    (a_al),
    .b_al    (b_al),
    .big_exp (big_exp)
  );

  fpaan_addsub #(.W(W), .EXP_W(EXP_W)) u_addsub (
    .a_sign     (a_sign),
    .b_sign     (b_sign),
    .a_al       (a_al),
    .b_al       (b_al),
    .exp_in     (big_exp),
    .round_down (round_down),
    .r_sign     (r_sign),
    .r_exp      (r_exp),
    .r_mant     (r_mant),
    .r_zero     (r_zero)
  );

  fpaan_norm_step #(.W(W), .EXP_W(EXP_W), .FAST_NORM(FAST_NORM)) u_norm (
    .mant_in  (w_mant),
    .exp_in   (w_exp),
    .mant_out (n_mant),
    .exp_out  (n_exp)
  );

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_sign  = w_sign;
  assign out_exp   = w_exp;
  assign out_mant  = w_mant;
  assign out_zero  = w_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      w_sign <= 1'b0;
      w_zero <= 1'b0;
      w_exp  <= '0;
      w_mant <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          w_sign <= r_sign;
          w_zero <= r_zero;
          w_exp  <= r_exp;
          w_mant <= r_mant;
          state  <= (r_zero || r_mant[W-1]) ? ST_DONE : ST_NORM;
        end
        ST_NORM: begin
          w_mant <= n_mant;
          w_exp  <= n_exp;
          if (n_mant[W-1]) state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpaan_checker.sv
module fpaan_checker #(
  parameter int W     = 27,
  parameter int EXP_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_sign,
  input logic [EXP_W-1:0] out_exp,
  input logic [W-1:0]     out_mant,
  input logic             out_zero
);
  // R1: an accepted pair closes the input until its result is handed off
  assert_accept_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R1: a result on offer and an open input never coincide
  assert_one_side_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R2: a stalled result is held unchanged
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sign) &&
      $stable(out_exp) && $stable(out_mant) && $stable(out_zero)));

  // R7: a zero result carries an all-zero significand and exponent
  assert_zero_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_mant == '0 && out_exp == '0));

  // R8: a nonzero result is normalized
  assert_normalized_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero) |-> out_mant[W-1]);
endmodule

bind fp_align_add_norm fpaan_checker #(
  .W     (MANT_W + fpaan_pkg::GRS_BITS),
  .EXP_W (EXP_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sign  (out_sign),
  .out_exp   (out_exp),
  .out_mant  (out_mant),
  .out_zero  (out_zero)
);

// File: tb/fp_align_add_norm_tb.sv
module fp_align_add_norm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic        a_sign = 1'b0, b_sign = 1'b0, round_down = 1'b0;
  logic [9:0]  a_exp = '0, b_exp = '0;
  logic [23:0] a_mant = '0, b_mant = '0;
  logic        out_valid, out_ready = 1'b0;
  logic        out_sign, out_zero;
  logic [9:0]  out_exp;
  logic [26:0] out_mant;

  int n_run = 0, n_fail = 0;
  int out_count = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_align_add_norm u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .a_sign (a_sign), .a_exp (a_exp), .a_mant (a_mant),
    .b_sign (b_sign), .b_exp (b_exp), .b_mant (b_mant),
    .round_down (round_down),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_sign (out_sign), .out_exp (out_exp), .out_mant (out_mant),
    .out_zero (out_zero)
  );

  always @(posedge clk) if (out_valid && out_ready) out_count <= out_count + 1;

  typedef struct packed {
    logic        as; logic [9:0] ae; logic [23:0] am;
    logic        bs; logic [9:0] be; logic [23:0] bm;
    logic        rd;
    logic        es; logic [9:0] ee; logic [26:0] em; logic ez;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,10'h000,24'h800000, 1'b0,10'h000,24'h800000, 1'b0, 1'b0,10'h001,27'h4000000,1'b0}, // R5 carry
    '{1'b0,10'h005,24'h800000, 1'b0,10'h003,24'h800000, 1'b0, 1'b0,10'h005,27'h5000000,1'b0}, // R3
    '{1'b0,10'h000,24'h800001, 1'b0,10'h3E2,24'h800000, 1'b0, 1'b0,10'h000,27'h4000009,1'b0}, // R4 gap 30
    '{1'b0,10'h004,24'h800000, 1'b0,10'h000,24'hC00001, 1'b0, 1'b0,10'h004,27'h4600001,1'b0}, // R3 sticky
    '{1'b0,10'h003,24'hFFFFFF, 1'b0,10'h000,24'h800001, 1'b0, 1'b0,10'h004,27'h43FFFFD,1'b0}, // R5 carry sticky
    '{1'b0,10'h000,24'h800000, 1'b1,10'h000,24'hC00000, 1'b0, 1'b1,10'h3FF,27'h4000000,1'b0}, // R6 b larger
    '{1'b0,10'h002,24'hA00000, 1'b1,10'h002,24'hA00000, 1'b1, 1'b1,10'h000,27'h0000000,1'b1}, // R7 -0
    '{1'b0,10'h002,24'hA00000, 1'b1,10'h002,24'hA00000, 1'b0, 1'b0,10'h000,27'h0000000,1'b1}, // R7 +0
    '{1'b0,10'h000,24'h800001, 1'b1,10'h000,24'h800000, 1'b0, 1'b0,10'h3E9,27'h4000000,1'b0}, // R8 23 shifts
    '{1'b0,10'h001,24'h800000, 1'b1,10'h3FE,24'hFFFFFF, 1'b0, 1'b0,10'h000,27'h6000002,1'b0}, // R8 one shift
    '{1'b1,10'h000,24'hC00000, 1'b0,10'h000,24'h800000, 1'b0, 1'b1,10'h3FF,27'h4000000,1'b0}, // R6 a larger
    '{1'b0,10'h3FF,24'h800000, 1'b1,10'h000,24'h800000, 1'b0, 1'b1,10'h3FF,27'h4000000,1'b0}, // R6 after align
    '{1'b1,10'h007,24'h900000, 1'b1,10'h007,24'h900000, 1'b0, 1'b1,10'h008,27'h4800000,1'b0}, // R5 negative
    '{1'b0,10'h01B,24'h800000, 1'b1,10'h000,24'h800000, 1'b0, 1'b0,10'h01A,27'h7FFFFFE,1'b0}  // R4 gap 27
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic offer(input vec_t v);
    @(negedge clk);
    a_sign = v.as; a_exp = v.ae; a_mant = v.am;
    b_sign = v.bs; b_exp = v.be; b_mant = v.bm;
    round_down = v.rd;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out();
    while (!out_valid) @(negedge clk);
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic compare(input string tag, input vec_t v);
    check({tag, " sign"}, 64'(out_sign), 64'(v.es));
    check({tag, " exp"},  64'(out_exp),  64'(v.ee));
    check({tag, " mant"}, 64'(out_mant), 64'(v.em));
    check({tag, " zero"}, 64'(out_zero), 64'(v.ez));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: state right after reset
    check("R9 out_valid", 64'(out_valid), 64'd0);
    check("R9 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      offer(VECS[i]);
      wait_out();
      compare($sformatf("vector %0d", i), VECS[i]);
      take();
    end

    // R1: operands offered while busy are ignored; one result per pair
    begin
      int base;
      vec_t other;
      base  = out_count;
      other = VECS[0];
      @(negedge clk);
      a_sign = VECS[8].as; a_exp = VECS[8].ae; a_mant = VECS[8].am;
      b_sign = VECS[8].bs; b_exp = VECS[8].be; b_mant = VECS[8].bm;
      round_down = VECS[8].rd;
      in_valid = 1'b1;
      @(negedge clk);
      check("R1 busy in_ready", 64'(in_ready), 64'd0);
      a_sign = other.as; a_exp = other.ae; a_mant = other.am;
      b_sign = other.bs; b_exp = other.be; b_mant = other.bm;
      while (!out_valid) @(negedge clk);
      in_valid = 1'b0;
      // R2: stall the consumer and watch the result hold
      repeat (4) begin
        @(negedge clk);
        check("R2 held valid", 64'(out_valid), 64'd1);
        check("R2 held in_ready", 64'(in_ready), 64'd0);
      end
      compare("R1 first operands kept", VECS[8]);
      take();
      repeat (5) @(negedge clk);
      check("R1 single transfer", 64'(out_count - base), 64'd1);
      check("R1 ready after handoff", 64'(in_ready), 64'd1);
    end

    // R9: reset in mid-operation returns to idle
    offer(VECS[8]);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid reset out_valid", 64'(out_valid), 64'd0);
    check("R9 mid reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule